// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional buses, A and B, each split into lanes (two 8-bit lanes by default) that can run on their own or together as one 16-bit path. For each lane and each direction there is a storage register with its own rising-edge capture clock, a source select and a drive enable. The select picks either the live value of the opposite bus or the captured value as the data to drive. The enable decides whether that data reaches the bus at all. A-to-B drive is enabled by a high level and B-to-A drive by a low level.

The buses appear at the ports in split form. Each bus has an input vector (the resolved bus level), an output vector (the value the block would drive) and a per-lane drive enable that stands for the tri-state control. The surrounding fabric resolves the drivers. Captures happen on every rising edge of a direction's clock, whatever the select and enable levels. A synchronous active-low reset clears a register on that register's own clock edge. While reset is held low, all drive enables are forced off, so both buses float. The selector is built so that a bit whose live and stored values agree never moves when the select changes.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A rising capture-clock edge taken while rst_n is low clears that lane's register for that direction to zero, so stored-mode output reads 0 after reset.
- R2: While rst_n is low, every bit of a_oe and b_oe is 0, whatever oe_ab and oe_ba_n are.
- R3: With sel_ab low, b_o equals a_i of the same lane; with sel_ba low, a_o equals b_i of the same lane (live transfer, no clock needed).
- R4: With rst_n high, b_oe of a lane equals oe_ab of that lane (active high) and a_oe equals the inverse of oe_ba_n (active low); a disabled direction leaves its bus undriven.
- R5: A rising edge of clk_ab captures a_i into the A-to-B register, and a rising edge of clk_ba captures b_i into the B-to-A register, regardless of sel and enable levels; an edge on one direction's clock leaves the other register unchanged.
- R6: With sel_ab high, b_o carries the A-to-B register; with sel_ba high, a_o carries the B-to-A register; a capture edge in stored mode shows the new value on the output right after that edge.
- R7: Lane h occupies bits [8h+7:8h]; its clocks, selects and enables affect only those bits.
- R8: For any bit whose live and stored values are equal, toggling the select leaves that output bit unchanged.
- R9: With both selects low and both directions enabled, each bus is driven from the other, so both buses keep their last value once every external driver releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset; also forces all drive enables off |
| clk_ab | input | HALVES | Per-lane rising-edge capture clock of the A-to-B register |
| clk_ba | input | HALVES | Per-lane rising-edge capture clock of the B-to-A register |
| sel_ab | input | HALVES | Per-lane A-to-B source: 0 live bus A, 1 stored register |
| sel_ba | input | HALVES | Per-lane B-to-A source: 0 live bus B, 1 stored register |
| oe_ab | input | HALVES | Per-lane A-to-B drive enable, active high |
| oe_ba_n | input | HALVES | Per-lane B-to-A drive enable, active low |
| a_i | input | HALF_W*HALVES | Resolved level of bus A |
| a_o | output | HALF_W*HALVES | Value driven onto bus A when enabled |
| a_oe | output | HALVES | Per-lane tri-state enable for bus A |
| b_i | input | HALF_W*HALVES | Resolved level of bus B |
| b_o | output | HALF_W*HALVES | Value driven onto bus B when enabled |
| b_oe | output | HALVES | Per-lane tri-state enable for bus B |

## Verification
A capture edge and a stored-mode drive can land on the same edge. The register that is being written is also the source of the driven bus. The bench sets sel_ab and oe_ab high, changes bus A, then raises clk_ab. It requires b_o to show the old content just before the edge and the newly captured word right after it. It runs the same case with only one lane clocked, to confirm the other lane keeps its value and the B-to-A register is left alone.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes: lanes are of equal width; the default geometry is two 8-bit lanes.
package xcvr_pkg;

    // Default lane geometry.
    localparam int unsigned DEF_HALF_W = 8;
    localparam int unsigned DEF_HALVES = 2;

    // Source choice for one direction of one lane.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    // Turn a raw select level into a source choice.
    function automatic src_e to_src(input logic sel);
        return sel ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/xfer_reg.sv
// Capture register for one direction of one lane.
// Loads d on every rising edge of clk. It has no enable, so the capture does
// not depend on select or drive state. A low rst_n sampled at the edge clears it.
// Assumes: rst_n is held low across at least one edge of clk during power-up.
module xfer_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the opposite bus, or clear while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/hazard_free_mux.sv
// Two-way bitwise selector between the live bus and the stored register.
// A consensus term (live AND stored) covers each bit while the select moves,
// so a bit whose two sources agree holds its level through the change.
// Assumes: the select may change at any time, asynchronously to any clock.
module hazard_free_mux #(
    parameter int unsigned W = 8
) (
    input  xcvr_pkg::src_e src,
    input  logic [W-1:0]   live,
    input  logic [W-1:0]   stored,
    output logic [W-1:0]   y
);
    import xcvr_pkg::*;

    logic [W-1:0] pick_st;
    logic [W-1:0] pick_lv;
    logic [W-1:0] agree;

    // Expand the source choice to per-bit steering terms.
    always_comb begin
        pick_st = {W{src == SRC_STORED}};
        pick_lv = {W{src == SRC_LIVE}};
    end

    // Bits whose sources agree, held regardless of the select.
    always_comb agree = live & stored;

    // Sum of products plus the consensus term.
    always_comb y = (live & pick_lv) | (stored & pick_st) | agree;

endmodule

// File: rtl/xcvr_lane.sv
// One lane of the transceiver: an A-to-B path and a B-to-A path. Each path
// has its own capture register, clock, source select and drive enable.
// A-to-B drive is enabled by a high level and B-to-A drive by a low level.
// Both drive enables are held off while rst_n is low.
// Assumes: the enclosing fabric resolves bus levels and feeds them back on a_i/b_i.
module xcvr_lane #(
    parameter int unsigned W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o,
    output logic         b_oe
);
    import xcvr_pkg::*;

    logic [W-1:0] q_ab;
    logic [W-1:0] q_ba;
    src_e         src_ab;
    src_e         src_ba;

    // A-to-B storage, clocked by its own capture clock.
    xfer_reg #(.W(W)) u_reg_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_i),
        .q     (q_ab)
    );

    // B-to-A storage, clocked by its own capture clock.
    xfer_reg #(.W(W)) u_reg_ba (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_i),
        .q     (q_ba)
    );

    // Decode the raw select levels.
    always_comb begin
        src_ab = to_src(sel_ab);
        src_ba = to_src(sel_ba);
    end

    // Data toward bus B.
    hazard_free_mux #(.W(W)) u_mux_ab (
        .src    (src_ab),
        .live   (a_i),
        .stored (q_ab),
        .y      (b_o)
    );

    // Data toward bus A.
    hazard_free_mux #(.W(W)) u_mux_ba (
        .src    (src_ba),
        .live   (b_i),
        .stored (q_ba),
        .y      (a_o)
    );

    // Drive enables with their opposite polarities, forced off during reset.
    always_comb begin
        b_oe = rst_n & oe_ab;
        a_oe = rst_n & ~oe_ba_n;
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
// Registered bidirectional bus transceiver, built as HALVES independent lanes
// of HALF_W bits each. Lane h owns bits [h*HALF_W +: HALF_W] of both buses
// and has its own clocks, selects and enables.
// Assumes: buses are given in split form (input level, output value,
// per-lane drive enable) and resolved outside this block.
module bus_xcvr_reg #(
    parameter int unsigned HALF_W = xcvr_pkg::DEF_HALF_W,
    parameter int unsigned HALVES = xcvr_pkg::DEF_HALVES,
    localparam int unsigned BUS_W = HALF_W * HALVES
) (
    input  logic              rst_n,
    input  logic [HALVES-1:0] clk_ab,
    input  logic [HALVES-1:0] clk_ba,
    input  logic [HALVES-1:0] sel_ab,
    input  logic [HALVES-1:0] sel_ba,
    input  logic [HALVES-1:0] oe_ab,
    input  logic [HALVES-1:0] oe_ba_n,
    input  logic [BUS_W-1:0]  a_i,
    output logic [BUS_W-1:0]  a_o,
    output logic [HALVES-1:0] a_oe,
    input  logic [BUS_W-1:0]  b_i,
    output logic [BUS_W-1:0]  b_o,
    output logic [HALVES-1:0] b_oe
);

    // One lane instance per slice of the bus.
    for (genvar h = 0; h < HALVES; h++) begin : g_lane
        xcvr_lane #(.W(HALF_W)) u_lane (
            .rst_n   (rst_n),
            .clk_ab  (clk_ab[h]),
            .clk_ba  (clk_ba[h]),
            .sel_ab  (sel_ab[h]),
            .sel_ba  (sel_ba[h]),
            .oe_ab   (oe_ab[h]),
            .oe_ba_n (oe_ba_n[h]),
            .a_i     (a_i[h*HALF_W +: HALF_W]),
            .a_o     (a_o[h*HALF_W +: HALF_W]),
            .a_oe    (a_oe[h]),
            .b_i     (b_i[h*HALF_W +: HALF_W]),
            .b_o     (b_o[h*HALF_W +: HALF_W]),
            .b_oe    (b_oe[h])
        );
    end

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
// Property checker for bus_xcvr_reg, attached through bind. Clocked checks
// sample on each lane's own capture clocks; enable checks are immediate.
// Assumes: the same parameters as the checked instance.
module bus_xcvr_reg_chk #(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned HALVES = 2,
    localparam int unsigned BUS_W = HALF_W * HALVES
) (
    input logic              rst_n,
    input logic [HALVES-1:0] clk_ab,
    input logic [HALVES-1:0] clk_ba,
    input logic [HALVES-1:0] sel_ab,
    input logic [HALVES-1:0] sel_ba,
    input logic [HALVES-1:0] oe_ab,
    input logic [HALVES-1:0] oe_ba_n,
    input logic [BUS_W-1:0]  a_i,
    input logic [BUS_W-1:0]  a_o,
    input logic [HALVES-1:0] a_oe,
    input logic [BUS_W-1:0]  b_i,
    input logic [BUS_W-1:0]  b_o,
    input logic [HALVES-1:0] b_oe
);

    // Reset quiets both buses (R2); enable polarity otherwise (R4).
    always_comb begin
        if (!rst_n) begin
            p_reset_float_r2: assert (a_oe == '0 && b_oe == '0);
        end else begin
            p_oe_polarity_r4: assert (b_oe == oe_ab && a_oe == ~oe_ba_n);
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        // Live A-to-B transfer at each A-to-B edge (R3).
        p_live_ab_r3: assert property (@(posedge clk_ab[h]) disable iff (!rst_n)
            !sel_ab[h] |-> b_o[h*HALF_W +: HALF_W] == a_i[h*HALF_W +: HALF_W]);

        // Live B-to-A transfer at each B-to-A edge (R3).
        p_live_ba_r3: assert property (@(posedge clk_ba[h]) disable iff (!rst_n)
            !sel_ba[h] |-> a_o[h*HALF_W +: HALF_W] == b_i[h*HALF_W +: HALF_W]);

        // Stored A-to-B output is what bus A held at the previous edge (R6).
        p_stored_ab_r6: assert property (@(posedge clk_ab[h]) disable iff (!rst_n)
            ($past(rst_n) && sel_ab[h]) |->
                b_o[h*HALF_W +: HALF_W] == $past(a_i[h*HALF_W +: HALF_W]));

        // Stored B-to-A output is what bus B held at the previous edge (R6).
        p_stored_ba_r6: assert property (@(posedge clk_ba[h]) disable iff (!rst_n)
            ($past(rst_n) && sel_ba[h]) |->
                a_o[h*HALF_W +: HALF_W] == $past(b_i[h*HALF_W +: HALF_W]));
    end

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (.*);

// File: tb/tb_bus_xcvr_reg.sv
// Directed bench for bus_xcvr_reg. It models the two buses by resolving the
// external drivers and the block's drivers in a timed settle loop.
module tb_bus_xcvr_reg;
    localparam int CLK_P = 10;
    localparam int HW    = 8;
    localparam int NH    = 2;
    localparam int BW    = HW * NH;

    logic          rst_n;
    logic [NH-1:0] clk_ab, clk_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic [BW-1:0] a_i, b_i;
    logic [BW-1:0] a_o, b_o;
    logic [NH-1:0] a_oe, b_oe;

    logic [BW-1:0] ext_a, ext_b;
    logic [NH-1:0] ext_a_en, ext_b_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    bus_xcvr_reg #(.HALF_W(HW), .HALVES(NH)) dut (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
        .b_i(b_i), .b_o(b_o), .b_oe(b_oe)
    );

    // Resolve both buses a few times so that feedback through the block settles.
    task automatic settle();
        for (int k = 0; k < 4; k++) begin
            logic [BW-1:0] na, nb;
            #1;
            for (int h = 0; h < NH; h++) begin
                na[h*HW +: HW] = ext_a_en[h] ? ext_a[h*HW +: HW] :
                                 (a_oe[h] ? a_o[h*HW +: HW] : '0);
                nb[h*HW +: HW] = ext_b_en[h] ? ext_b[h*HW +: HW] :
                                 (b_oe[h] ? b_o[h*HW +: HW] : '0);
            end
            a_i = na;
            b_i = nb;
        end
        #1;
    endtask

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_ab(input logic [NH-1:0] m);
        clk_ab = m;      settle();
        #(CLK_P/2);
        clk_ab = '0;     settle();
    endtask

    task automatic pulse_ba(input logic [NH-1:0] m);
        clk_ba = m;      settle();
        #(CLK_P/2);
        clk_ba = '0;     settle();
    endtask

    // R1, R2: reset clears registers and floats both buses.
    task automatic t_reset();
        rst_n = 0; oe_ab = '1; oe_ba_n = '0; sel_ab = '1; sel_ba = '1;
        ext_a = 16'hFFFF; ext_b = 16'hFFFF; ext_a_en = '1; ext_b_en = '1;
        settle();
        chk("R2 a_oe in reset", BW'(a_oe), '0);
        chk("R2 b_oe in reset", BW'(b_oe), '0);
        pulse_ab('1); pulse_ba('1);
        rst_n = 1; ext_a_en = '0; ext_b_en = '0; oe_ab = '0; oe_ba_n = '1;
        settle();
        chk("R1 A-to-B register cleared", b_o, '0);
        chk("R1 B-to-A register cleared", a_o, '0);
    endtask

    // R3, R4: live transfer in both directions with enable polarity.
    task automatic t_live();
        sel_ab = '0; sel_ba = '0; oe_ab = '1; oe_ba_n = '1;
        ext_a_en = '1; ext_a = 16'hA55A; settle();
        chk("R3 live A to B", b_i, 16'hA55A);
        chk("R4 b_oe active high", BW'(b_oe), BW'(2'b11));
        chk("R4 a_oe off when oe_ba_n high", BW'(a_oe), '0);
        ext_a = 16'h0FF0; settle();
        chk("R3 live A to B second pattern", b_o, 16'h0FF0);
        oe_ab = '0; oe_ba_n = '0; ext_a_en = '0; ext_b_en = '1; ext_b = 16'h3C96; settle();
        chk("R3 live B to A", a_i, 16'h3C96);
        chk("R4 a_oe active low", BW'(a_oe), BW'(2'b11));
        chk("R4 b_oe off when oe_ab low", BW'(b_oe), '0);
        ext_b_en = '0; oe_ba_n = '1; settle();
    endtask

    // R5, R6: capture while disabled and live-selected, then drive stored data.
    task automatic t_capture();
        sel_ab = '0; sel_ba = '0; oe_ab = '0; oe_ba_n = '1;
        ext_a_en = '1; ext_a = 16'h1234; settle();
        pulse_ab('1);
        ext_a = 16'hFFFF; sel_ab = '1; oe_ab = '1; settle();
        chk("R5/R6 A-to-B captured while disabled", b_i, 16'h1234);
        ext_a_en = '0; oe_ab = '0;
        ext_b_en = '1; ext_b = 16'h5AA5; settle();
        pulse_ba('1);
        ext_b = 16'h0000; ext_b_en = '0; sel_ba = '1; oe_ba_n = '0; settle();
        chk("R5/R6 B-to-A captured while disabled", a_i, 16'h5AA5);
    endtask

    // R7, R5, R6: one lane clocked; capture and stored drive on the same edge.
    task automatic t_lanes();
        oe_ba_n = '1; sel_ab = '1; oe_ab = '1; ext_a_en = '1; ext_a = 16'hBEEF; settle();
        pulse_ab(2'b10);
        chk("R7 only upper lane captured", b_o, 16'hBE34);
        sel_ba = '1; settle();
        chk("R5 A-to-B edge leaves B-to-A register", a_o, 16'h5AA5);
        ext_a = 16'h7788; settle();
        chk("R6 stored value before edge", b_o, 16'hBE34);
        pulse_ab('1);
        chk("R6 new capture shown after edge", b_o, 16'h7788);
    endtask

    // R8: select toggles with equal sources must not move the output.
    task automatic t_glitch();
        int bad = 0;
        ext_a = 16'h7788; settle();
        for (int k = 0; k < 8; k++) begin
            sel_ab = ~sel_ab;
            #1;
            if (b_o !== 16'h7788) bad++;
        end
        chk("R8 output steady across select toggles", BW'(bad), '0);
        ext_a = 16'h7700; sel_ab = '1; settle();
        sel_ab = '0; #1;
        chk("R8 agreeing bits steady, others follow", b_o, 16'h7700);
    endtask

    // R9: both live and both enabled hold the last value after release.
    task automatic t_mutual();
        sel_ab = '0; sel_ba = '0; oe_ab = '1; oe_ba_n = '0;
        ext_b_en = '0; ext_a_en = '1; ext_a = 16'hC3C3; settle();
        ext_a_en = '0; settle(); settle();
        chk("R9 bus A holds", a_i, 16'hC3C3);
        chk("R9 bus B holds", b_i, 16'hC3C3);
        ext_b_en = '1; ext_b = 16'h1E1E; settle();
        ext_b_en = '0; settle(); settle();
        chk("R9 bus A follows then holds", a_i, 16'h1E1E);
        chk("R9 bus B holds after release", b_i, 16'h1E1E);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clk_ab = '0; clk_ba = '0; a_i = '0; b_i = '0;
        sel_ab = '0; sel_ba = '0; oe_ab = '0; oe_ba_n = '1; rst_n = 0;
        ext_a = '0; ext_b = '0; ext_a_en = '0; ext_b_en = '0;
        #(CLK_P);
        t_reset();
        t_live();
        t_capture();
        t_lanes();
        t_glitch();
        t_mutual();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule